// File: doc/BRIEF.md
# SPI Register Command Slave

This block is the command and register side of a radio transceiver, seen from an SPI host. Each transaction is framed by the active-low chip select. The first byte after select is a command. While that byte shifts in, the block shifts out its status byte. Any later bytes are register data, either written into or read from the addressed register.

Most registers hold one byte, each with its own writable bit mask. Three address registers are longer: the transmit address and the receive addresses of pipes 0 and 1. Their length, from 3 to 5 bytes, comes from a width field, and their bytes travel least significant first. The receive addresses of pipes 2 to 5 are one byte each.

Surrounding logic drives the status flags through a side port. It raises the receive-ready, transmit-done and retry-limit flags with single-cycle pulses, and it supplies the receive pipe number and the transmit-full level. The SPI host clears a flag by writing a 1 to it. SCK, MOSI and CSN are sampled in the system clock domain, so SCK must run at most one eighth of the system clock rate.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, the status byte is 0x0E (no flags, pipe field 7, transmit-full 0). The width register 0x03 reads 0x03. Every other register reads 0.
- R2: SPI runs in mode 0 with 8-bit frames, MSB first. The status byte appears on MISO during every command byte, whatever the command. MISO is 0 while CSN is high.
- R3: Command 0b000aaaaa reads register a and command 0b001aaaaa writes it. For one-byte registers, only the first data byte counts. Writable masks: 0x00 0x7F, 0x01 0x3F, 0x02 0x3F, 0x03 0x03, 0x04 0xFF, 0x05 0x7F, 0x06 0xFF, 0x1C 0x3F, 0x1D 0x07. Masked-off bits read 0.
- R4: Any command whose top three bits are neither 000 nor 001 (0xFF no-operation included) changes no register. Its data bytes return 0x00.
- R5: Status bit 6 is receive-ready, bit 5 transmit-done and bit 4 retry-limit. A side-port pulse sets its flag. Writing a 1 to one of these bits at address 0x07 clears that flag, and writing 0 leaves it. A set in the same cycle as a clear wins.
- R6: While receive-ready is set, status bits 3:1 hold the pipe number captured on the most recent receive-ready pulse. While it is clear, they read 7.
- R7: Status bit 0 follows the transmit-full input.
- R8: Registers 0x0A, 0x0B and 0x10 move least significant byte first. Their length is set by register 0x03 bits 1:0: code 1 gives 3 bytes, 2 gives 4, 3 gives 5, and 0 is taken as 3. Write bytes beyond that length are dropped, and read bytes beyond it return 0.
- R9: Registers 0x0C to 0x0F hold one full byte each. A second data byte is dropped on write and reads back as 0.
- R10: The payload width registers 0x11 to 0x16 keep only their low 6 bits.
- R11: A transaction ends when CSN rises. A partly shifted byte is discarded, and the bit count restarts at the next select.
- R12: Addresses 0x08, 0x09, 0x17 to 0x1B, 0x1E and 0x1F read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; SPI pins are sampled with it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI clock, idle low |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| tx_full_i | input | 1 | Transmit-full level shown in status bit 0 |
| rx_pipe_i | input | 3 | Pipe number captured with a receive-ready pulse |
| max_rt_set_i | input | 1 | Pulse that sets the retry-limit flag |
| tx_ds_set_i | input | 1 | Pulse that sets the transmit-done flag |
| rx_dr_set_i | input | 1 | Pulse that sets the receive-ready flag |

## Verification
A corrupt flag or pipe capture shows up in the very next transaction: the command byte of every frame returns the status byte. Bad register storage or a wrong write mask shows up only when that register is read back. So every write is followed by a longer read of the same address, and each storage fault surfaces within two frames. A wrong address-width decode shifts where the zero bytes begin in a long read, and a slipped bit counter misaligns every later byte of the same frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned N_REGS  = 1 << REG_AW;
  localparam int unsigned N_LONG  = 3;
  localparam int unsigned N_FLAGS = 3;

  localparam logic [REG_AW-1:0] A_WIDTH  = 5'h03;
  localparam logic [REG_AW-1:0] A_STATUS = 5'h07;
  localparam logic [REG_AW-1:0] A_RXA0   = 5'h0A;
  localparam logic [REG_AW-1:0] A_RXA1   = 5'h0B;
  localparam logic [REG_AW-1:0] A_TXA    = 5'h10;

  typedef enum logic [1:0] {CMD_NONE, CMD_RD, CMD_WR} cmd_e;

  function automatic logic [BYTE_W-1:0] wr_mask(input logic [REG_AW-1:0] a);
    case (a)
      5'h00, 5'h05:                             wr_mask = 8'h7F;
      5'h01, 5'h02, 5'h1C:                      wr_mask = 8'h3F;
      5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16: wr_mask = 8'h3F;
      5'h03:                                    wr_mask = 8'h03;
      5'h1D:                                    wr_mask = 8'h07;
      5'h04, 5'h06, 5'h0C, 5'h0D, 5'h0E, 5'h0F: wr_mask = 8'hFF;
      default:                                  wr_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] rst_val(input logic [REG_AW-1:0] a);
    rst_val = (a == A_WIDTH) ? 8'h03 : 8'h00;
  endfunction

  function automatic logic is_long(input logic [REG_AW-1:0] a);
    is_long = (a == A_RXA0) || (a == A_RXA1) || (a == A_TXA);
  endfunction

  function automatic logic [1:0] long_sel(input logic [REG_AW-1:0] a);
    case (a)
      A_RXA0:  long_sel = 2'd0;
      A_RXA1:  long_sel = 2'd1;
      default: long_sel = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/spi_byte_port.sv
module spi_byte_port
  import spi_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              active_o,
  output logic              start_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              miso_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [2:0]        sck_s;
  logic [1:0]        mosi_s, csn_s;
  logic              csn_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shift_in, shift_out;
  logic              done_q;
  logic              sck_rise, sck_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s  <= '0;
      mosi_s <= '0;
      csn_s  <= '1;
      csn_d  <= 1'b1;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      csn_s  <= {csn_s[0], csn_i};
      csn_d  <= csn_s[1];
    end
  end

  assign active_o = ~csn_s[1];
  assign start_o  = csn_d & ~csn_s[1];
  assign sck_rise = sck_s[1] & ~sck_s[2];
  assign sck_fall = ~sck_s[1] & sck_s[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      shift_in  <= '0;
      shift_out <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_o) begin
        bit_cnt   <= '0;
        shift_out <= '0;
      end else if (start_o) begin
        bit_cnt   <= '0;
        shift_out <= status_i;
      end else begin
        if (sck_rise) begin
          shift_in <= {shift_in[BYTE_W-2:0], mosi_s[1]};
          bit_cnt  <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W-1)) done_q <= 1'b1;
        end
        // next byte is loaded on the fall that follows the last rise of a byte
        if (sck_fall)
          shift_out <= (bit_cnt == '0) ? tx_byte_i : {shift_out[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign byte_done_o = done_q;
  assign byte_o      = shift_in;
  assign miso_o      = active_o & shift_out[BYTE_W-1];

  AST_STATUS_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> shift_out == $past(status_i)); // R2
  AST_BYTE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> $past(active_o)); // R11
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_reg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_FLAGS-1:0] set_i,   // {rx ready, tx done, retry limit}
  input  logic [N_FLAGS-1:0] clr_i,
  input  logic [2:0]         rx_pipe_i,
  input  logic               tx_full_i,
  output logic [BYTE_W-1:0]  status_o
);
  logic [N_FLAGS-1:0] flags;
  logic [2:0]         pipe_q;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign flags[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pipe_q <= '0;
    else if (set_i[N_FLAGS-1])   pipe_q <= rx_pipe_i;
  end

  assign status_o = {1'b0, flags, flags[N_FLAGS-1] ? pipe_q : 3'd7, tx_full_i};

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[N_FLAGS-1] |=> status_o[6]); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[0] && !set_i[0]) |=> !status_o[4]); // R5
  AST_PIPE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[N_FLAGS-1] |=> status_o[3:1] == $past(rx_pipe_i)); // R6
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_BYTES_MAX = 5,
  localparam int unsigned IDX_W = $clog2(ADDR_BYTES_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] one_q  [N_REGS];
  logic [BYTE_W-1:0] long_q [N_LONG][ADDR_BYTES_MAX];
  logic [IDX_W-1:0]  len;

  always_comb begin
    case (one_q[A_WIDTH][1:0])
      2'd2:    len = IDX_W'(4);
      2'd3:    len = IDX_W'(5);
      default: len = IDX_W'(3);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < N_REGS; a++) one_q[a] <= rst_val(REG_AW'(a));
    end else if (wr_en_i && wr_idx_i == '0 && !is_long(wr_addr_i)) begin
      one_q[wr_addr_i] <= wr_data_i & wr_mask(wr_addr_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < N_LONG; r++)
        for (int b = 0; b < ADDR_BYTES_MAX; b++) long_q[r][b] <= '0;
    end else if (wr_en_i && is_long(wr_addr_i) && wr_idx_i < len) begin
      long_q[long_sel(wr_addr_i)][wr_idx_i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_STATUS) begin
      if (rd_idx_i == '0) rd_data_o = status_i;
    end else if (is_long(rd_addr_i)) begin
      if (rd_idx_i < len) rd_data_o = long_q[long_sel(rd_addr_i)][rd_idx_i];
    end else if (rd_idx_i == '0) begin
      rd_data_o = one_q[rd_addr_i];
    end
  end

  AST_PW_LOW6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i >= 5'h11 && rd_addr_i <= 5'h16) |-> rd_data_o[7:6] == 2'b00); // R10
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_BYTES_MAX = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       tx_full_i,
  input  logic [2:0] rx_pipe_i,
  input  logic       max_rt_set_i,
  input  logic       tx_ds_set_i,
  input  logic       rx_dr_set_i
);
  localparam int unsigned IDX_W = $clog2(ADDR_BYTES_MAX + 1);

  logic              active, start, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte, status_byte, rd_data;
  logic              first_q;
  cmd_e              kind_q;
  logic [REG_AW-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wr_en;
  logic [N_FLAGS-1:0] flag_clr;

  spi_byte_port u_port (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i,
    .status_i   (status_byte),
    .tx_byte_i  (tx_byte),
    .active_o   (active),
    .start_o    (start),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte),
    .miso_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b1;
      kind_q  <= CMD_NONE;
      addr_q  <= '0;
      idx_q   <= '0;
    end else if (start) begin
      first_q <= 1'b1;
      kind_q  <= CMD_NONE;
      idx_q   <= '0;
    end else if (byte_done) begin
      if (first_q) begin
        first_q <= 1'b0;
        addr_q  <= rx_byte[REG_AW-1:0];
        idx_q   <= '0;
        case (rx_byte[7:5])
          3'b000:  kind_q <= CMD_RD;
          3'b001:  kind_q <= CMD_WR;
          default: kind_q <= CMD_NONE;
        endcase
      end else if (idx_q != '1) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign wr_en    = byte_done && !first_q && kind_q == CMD_WR;
  assign flag_clr = (wr_en && addr_q == A_STATUS && idx_q == '0) ? rx_byte[6:4] : '0;
  assign tx_byte  = (kind_q == CMD_RD && !first_q) ? rd_data : '0;

  spi_status_flags u_status (
    .clk_i, .rst_ni,
    .set_i    ({rx_dr_set_i, tx_ds_set_i, max_rt_set_i}),
    .clr_i    (flag_clr),
    .rx_pipe_i,
    .tx_full_i,
    .status_o (status_byte)
  );

  spi_reg_bank #(.ADDR_BYTES_MAX(ADDR_BYTES_MAX)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i  (wr_en),
    .wr_addr_i(addr_q),
    .wr_idx_i (idx_q),
    .wr_data_i(rx_byte),
    .rd_addr_i(addr_q),
    .rd_idx_i (idx_q),
    .status_i (status_byte),
    .rd_data_o(rd_data)
  );

  AST_MISO_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active) |-> !miso_o); // R2
endmodule

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, miso;
  logic tx_full = 1'b0;
  logic [2:0] rx_pipe = '0;
  logic max_rt_set = 1'b0, tx_ds_set = 1'b0, rx_dr_set = 1'b0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];

  logic [7:0] m_one [32];
  logic [7:0] m_long [3][5];
  logic [2:0] m_flags;
  logic [2:0] m_pipe;

  always #10 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .tx_full_i(tx_full), .rx_pipe_i(rx_pipe),
    .max_rt_set_i(max_rt_set), .tx_ds_set_i(tx_ds_set), .rx_dr_set_i(rx_dr_set)
  );

  function automatic logic [7:0] mask_of(input int a);
    case (a)
      8'h00, 8'h05: return 8'h7F;
      8'h01, 8'h02, 8'h1C, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16: return 8'h3F;
      8'h03: return 8'h03;
      8'h1D: return 8'h07;
      8'h04, 8'h06, 8'h0C, 8'h0D, 8'h0E, 8'h0F: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int long_idx(input int a);
    if (a == 8'h0A) return 0;
    if (a == 8'h0B) return 1;
    if (a == 8'h10) return 2;
    return -1;
  endfunction

  function automatic int exp_len();
    case (m_one[3][1:0])
      2'd2: return 4;
      2'd3: return 5;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {1'b0, m_flags, m_flags[2] ? m_pipe : 3'd7, tx_full};
  endfunction

  function automatic logic [7:0] exp_read(input int a, input int i);
    int k = long_idx(a);
    if (a == 7) return (i == 0) ? exp_status() : 8'h00;
    if (k >= 0) return (i < exp_len()) ? m_long[k][i] : 8'h00;
    return (i == 0) ? m_one[a] : 8'h00;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic spi_xfer(input int n, input int last_bits);
    @(negedge clk);
    csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int b = 0; b < n; b++) begin
      int nb = (b == n - 1) ? last_bits : 8;
      logic [7:0] r = 8'h00;
      for (int i = 7; i >= 8 - nb; i--) begin
        mosi = tx_buf[b][i];
        repeat (HALF) @(negedge clk);
        r[i] = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
      rx_buf[b] = r;
    end
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (4) @(negedge clk);
    check({7'd0, miso}, 8'h00, "R2 miso idle");
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input int a, input int n);
    int k = long_idx(a);
    int len = exp_len();
    tx_buf[0] = 8'h20 | a[7:0];
    spi_xfer(n + 1, 8);
    check(rx_buf[0], exp_status(), "R2 status on write");
    if (a == 7) m_flags = m_flags & ~tx_buf[1][6:4];
    else if (k >= 0) begin
      for (int i = 0; i < n && i < len; i++) m_long[k][i] = tx_buf[i + 1];
    end else m_one[a] = tx_buf[1] & mask_of(a);
  endtask

  task automatic do_read(input int a, input int n, input string tag);
    tx_buf[0] = a[7:0];
    for (int i = 1; i < 8; i++) tx_buf[i] = 8'hFF;
    spi_xfer(n + 1, 8);
    check(rx_buf[0], exp_status(), "R2 status on read");
    for (int i = 0; i < n; i++) check(rx_buf[i + 1], exp_read(a, i), tag);
  endtask

  task automatic pulse(input logic [2:0] s, input logic [2:0] p);
    @(negedge clk);
    {rx_dr_set, tx_ds_set, max_rt_set} = s;
    rx_pipe = p;
    @(negedge clk);
    {rx_dr_set, tx_ds_set, max_rt_set} = 3'b000;
    m_flags = m_flags | s;
    if (s[2]) m_pipe = p;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v = $urandom(32'h1D5EED);
    for (int a = 0; a < 32; a++) m_one[a] = (a == 3) ? 8'h03 : 8'h00;
    for (int r = 0; r < 3; r++) for (int b = 0; b < 5; b++) m_long[r][b] = 8'h00;
    m_flags = 3'b000;
    m_pipe  = 3'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    tx_buf[0] = 8'hFF; tx_buf[1] = 8'hFF;
    spi_xfer(2, 8);
    check(rx_buf[0], 8'h0E, "R1 reset status");
    check(rx_buf[1], 8'h00, "R4 nop data byte");
    do_read(3, 1, "R1 width reset");
    check(rx_buf[1], 8'h03, "R1 width reads 3");
    do_read(0, 2, "R1 config reset");

    // R3 masks
    tx_buf[1] = 8'hFF; do_write(0, 1); do_read(0, 1, "R3 config mask");
    check(rx_buf[1], 8'h7F, "R3 config 7 bits");
    tx_buf[1] = 8'hA5; tx_buf[2] = 8'h11; do_write(4, 2); do_read(4, 2, "R3 full byte");

    // R4 other commands touch nothing
    tx_buf[0] = 8'hA0; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00;
    spi_xfer(3, 8);
    check(rx_buf[0], exp_status(), "R4 status on payload cmd");
    check(rx_buf[1], 8'h00, "R4 data byte zero");
    do_read(0, 1, "R4 config unchanged");
    do_read(4, 1, "R4 retry unchanged");

    // R5 R6 R7 status flags
    pulse(3'b100, 3'd2);
    do_read(7, 1, "R6 pipe captured");
    check(rx_buf[1], 8'h44, "R6 status 0x44");
    tx_full = 1'b1;
    pulse(3'b011, 3'd5);
    do_read(7, 1, "R7 tx full");
    check(rx_buf[1], 8'h75, "R5 R7 status 0x75");
    tx_buf[1] = 8'h20; do_write(7, 1);
    do_read(7, 1, "R5 clear tx done");
    check(rx_buf[1], 8'h55, "R5 status 0x55");
    tx_buf[1] = 8'h40; do_write(7, 1);
    do_read(7, 1, "R6 pipe seven after clear");
    check(rx_buf[1], 8'h1F, "R6 status 0x1F");
    tx_buf[1] = 8'h0F; do_write(7, 1);
    do_read(7, 1, "R5 zero bits keep flag");
    tx_buf[1] = 8'h10; do_write(7, 1);
    tx_full = 1'b0;
    do_read(7, 1, "R7 follows input");
    check(rx_buf[1], 8'h0E, "R5 R7 status 0x0E");

    // R8 long addresses
    for (int i = 1; i <= 6; i++) tx_buf[i] = 8'h10 + i[7:0];
    do_write(16, 6); do_read(16, 6, "R8 five byte tx addr");
    check(rx_buf[5], 8'h15, "R8 lsb first byte 4");
    tx_buf[1] = 8'h01; do_write(3, 1);
    do_read(16, 5, "R8 three byte view");
    for (int i = 1; i <= 5; i++) tx_buf[i] = 8'hC0 + i[7:0];
    do_write(10, 5);
    tx_buf[1] = 8'h00; do_write(3, 1);
    do_read(10, 5, "R8 code 0 as 3");
    tx_buf[1] = 8'h02; do_write(3, 1);
    do_read(10, 5, "R8 dropped bytes stay");
    check(rx_buf[4], 8'h00, "R8 byte 3 not written");

    // R9 R10 R12
    tx_buf[1] = 8'h9A; tx_buf[2] = 8'h77; do_write(13, 2); do_read(13, 2, "R9 single byte pipe");
    tx_buf[1] = 8'hFF; do_write(19, 1); do_read(19, 1, "R10 width low 6");
    check(rx_buf[1], 8'h3F, "R10 0x3F");
    tx_buf[1] = 8'hFF; do_write(8, 1); do_read(8, 1, "R12 unused reads 0");
    tx_buf[1] = 8'hFF; do_write(31, 1); do_read(31, 1, "R12 unused 0x1F");

    // R11 partial byte discarded
    tx_buf[0] = 8'h25; tx_buf[1] = 8'h6B;
    spi_xfer(2, 5);
    check(rx_buf[0], exp_status(), "R11 status");
    do_read(5, 1, "R11 partial write dropped");
    tx_buf[0] = 8'h25;
    spi_xfer(1, 3);
    do_read(5, 1, "R11 bit count restarts");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int a = int'($urandom_range(31));
      int n = int'($urandom_range(6, 1));
      for (int i = 1; i <= n; i++) tx_buf[i] = 8'($urandom);
      if ($urandom_range(3) == 0) pulse(3'($urandom), 3'($urandom));
      if ($urandom_range(4) == 0) tx_full = ~tx_full;
      do_write(a, n);
      do_read(a, n + 1, "R3 R8 R9 random readback");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule